// File: doc/BRIEF.md
# Masked Packed Narrowing Converter

This unit narrows a vector of 64-bit integer lanes to 32-bit results. One opcode byte picks the conversion: the low half of each lane is kept as it is, or the lane is clamped to the signed 32-bit range, or it is clamped to the unsigned 32-bit range. A length select sets how many lanes are active. Each result word lands in the destination in lane order, starting from the least-significant word.

A per-lane mask, with its own enable, picks the lanes that receive a converted value. The other lanes are zeroed or keep the prior destination word. This depends on the masking style and on whether the result goes to a register or to memory. A register result clears everything above the active lanes. A memory result leaves those bits untouched and reports a per-lane write enable. A reserved four-bit register field that is not all ones, an unknown opcode or the reserved length code marks the encoding illegal and blocks every write.

The result, the write enables and the illegal flag are registered one cycle after a single-cycle input strobe.

Top module: `narrow_conv_unit`

## Requirements
- R1: Opcode 0x35 keeps bits [31:0] of each lane. Opcode 0x25 saturates each lane as signed. Opcode 0x15 saturates each lane as unsigned. Any other opcode is illegal.
- R2: vsel 0, 1 and 2 make 2, 4 and 8 lanes active. vsel 3 is illegal.
- R3: Result lane j is computed from src bits [64j+63:64j] and is placed in out_data bits [32j+31:32j].
- R4: Signed saturation gives 0x7FFFFFFF for values above 2^31-1 and 0x80000000 for values below -2^31. Any other value passes as its low 32 bits.
- R5: Unsigned saturation gives 0xFFFFFFFF for any value above 0xFFFFFFFF. Any other value passes as its low 32 bits.
- R6: An active lane is converted when mask_en is 0 or its mask bit is 1. Otherwise, for a register destination (dst_mem=0), the lane is 0 when zero_mask=1 and keeps the old_dst word when zero_mask=0.
- R7: For a legal register destination, every out_data bit from 32 times the active lane count up to the top bit is 0.
- R8: For a memory destination (dst_mem=1), zero_mask is ignored and masked-off lanes keep old_dst. All bits above the active lanes also keep old_dst.
- R9: A reg_spec value other than 4'b1111 sets out_illegal. out_data then equals old_dst and out_wren is 0. The same holds for every other illegal encoding.
- R10: Results appear one cycle after in_valid, with out_valid high for exactly that cycle. out_wren bit j is 1 exactly when lane j is active, legal and converted.
- R11: After reset, out_valid, out_data, out_wren and out_illegal are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe that starts one conversion |
| opcode | input | 8 | Conversion opcode byte |
| vsel | input | 2 | Vector length select |
| reg_spec | input | 4 | Reserved register-specifier field |
| src | input | 512 | Eight 64-bit source lanes |
| old_dst | input | 512 | Prior destination contents |
| mask | input | 8 | Per-lane write mask |
| mask_en | input | 1 | Mask in use |
| zero_mask | input | 1 | 1 selects zeroing, 0 selects merging |
| dst_mem | input | 1 | Destination is memory |
| out_valid | output | 1 | Result valid |
| out_data | output | 512 | Registered destination value |
| out_wren | output | 8 | Per-lane write enable |
| out_illegal | output | 1 | Illegal encoding flag |

## Verification
On every cycle, the bound checker checks the valid timing, that illegal results carry no write enables, that write enables stay inside the active lanes and inside the mask, and that register results clear the upper half. It also checks that lane 0 clamps to the signed positive limit. The bench sweeps every opcode, length, destination kind and masking style across mask patterns and boundary lane values. It compares each word against an arithmetic model. Only these scenarios show the exact merged words, the zeroed words and the saturated values across all lanes.

// File: rtl/narrow_pkg.sv
package narrow_pkg;

    localparam int SRC_W = 64;
    localparam int DST_W = 32;

    typedef enum logic [1:0] {
        CV_TRUNC = 2'd0,
        CV_SSAT  = 2'd1,
        CV_USAT  = 2'd2,
        CV_NONE  = 2'd3
    } conv_e;

    typedef struct packed {
        logic  legal;
        conv_e mode;
    } dec_t;

    function automatic logic [DST_W-1:0] sat_signed(input logic [SRC_W-1:0] x);
        logic [SRC_W-DST_W:0] top;
        top = x[SRC_W-1:DST_W-1];
        if (top == '0 || top == '1)
            return x[DST_W-1:0];
        else if (x[SRC_W-1])
            return {1'b1, {(DST_W-1){1'b0}}};
        else
            return {1'b0, {(DST_W-1){1'b1}}};
    endfunction

    function automatic logic [DST_W-1:0] sat_unsigned(input logic [SRC_W-1:0] x);
        if (|x[SRC_W-1:DST_W])
            return '1;
        else
            return x[DST_W-1:0];
    endfunction

    function automatic logic [DST_W-1:0] narrow(input conv_e m, input logic [SRC_W-1:0] x);
        case (m)
            CV_SSAT: return sat_signed(x);
            CV_USAT: return sat_unsigned(x);
            default: return x[DST_W-1:0];
        endcase
    endfunction

endpackage

// File: rtl/narrow_decode.sv
module narrow_decode
    import narrow_pkg::*;
#(
    parameter int LANES = 8
) (
    input  logic [7:0]       opcode,
    input  logic [1:0]       vsel,
    input  logic [3:0]       reg_spec,
    output dec_t             dec,
    output logic [LANES-1:0] active
);
    conv_e      mode;
    logic [4:0] n_lanes;

    always_comb begin
        case (opcode)
            8'h35:   mode = CV_TRUNC;
            8'h25:   mode = CV_SSAT;
            8'h15:   mode = CV_USAT;
            default: mode = CV_NONE;
        endcase
        dec.mode  = mode;
        dec.legal = (mode != CV_NONE) && (reg_spec == 4'hF) && (vsel != 2'd3);
        n_lanes   = 5'd2 << vsel;
    end

    for (genvar j = 0; j < LANES; j++) begin : g_act
        assign active[j] = (5'(j) < n_lanes);
    end
endmodule

// File: rtl/narrow_lane.sv
module narrow_lane
    import narrow_pkg::*;
(
    input  conv_e            mode,
    input  logic             legal,
    input  logic             active,
    input  logic             take,
    input  logic             zero_sel,
    input  logic             to_mem,
    input  logic [SRC_W-1:0] x,
    input  logic [DST_W-1:0] old,
    output logic [DST_W-1:0] word,
    output logic             wr
);
    always_comb begin
        wr   = 1'b0;
        word = old;
        if (legal) begin
            if (active) begin
                if (take) begin
                    word = narrow(mode, x);
                    wr   = 1'b1;
                end else if (zero_sel) begin
                    word = '0;
                end
            end else if (!to_mem) begin
                word = '0;
            end
        end
    end
endmodule

// File: rtl/narrow_conv_unit.sv
module narrow_conv_unit
    import narrow_pkg::*;
#(
    parameter int LANES = 8,
    parameter int MAXVL = 512,
    localparam int SRC_ALL = LANES * SRC_W,
    localparam int LOW_W   = LANES * DST_W,
    localparam int UPPER_W = MAXVL - LOW_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [7:0]         opcode,
    input  logic [1:0]         vsel,
    input  logic [3:0]         reg_spec,
    input  logic [SRC_ALL-1:0] src,
    input  logic [MAXVL-1:0]   old_dst,
    input  logic [LANES-1:0]   mask,
    input  logic               mask_en,
    input  logic               zero_mask,
    input  logic               dst_mem,
    output logic               out_valid,
    output logic [MAXVL-1:0]   out_data,
    output logic [LANES-1:0]   out_wren,
    output logic               out_illegal
);
    dec_t             dec;
    logic [LANES-1:0] active;
    logic [MAXVL-1:0] nxt_data;
    logic [LANES-1:0] nxt_wren;
    logic             zero_sel;

    assign zero_sel = zero_mask && !dst_mem;

    narrow_decode #(.LANES(LANES)) u_dec (
        .opcode   (opcode),
        .vsel     (vsel),
        .reg_spec (reg_spec),
        .dec      (dec),
        .active   (active)
    );

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        narrow_lane u_lane (
            .mode     (dec.mode),
            .legal    (dec.legal),
            .active   (active[j]),
            .take     (!mask_en || mask[j]),
            .zero_sel (zero_sel),
            .to_mem   (dst_mem),
            .x        (src[j*SRC_W +: SRC_W]),
            .old      (old_dst[j*DST_W +: DST_W]),
            .word     (nxt_data[j*DST_W +: DST_W]),
            .wr       (nxt_wren[j])
        );
    end

    if (UPPER_W > 0) begin : g_upper
        assign nxt_data[MAXVL-1:LOW_W] =
            (dec.legal && !dst_mem) ? '0 : old_dst[MAXVL-1:LOW_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_data    <= '0;
            out_wren    <= '0;
            out_illegal <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data    <= nxt_data;
                out_wren    <= nxt_wren;
                out_illegal <= !dec.legal;
            end
        end
    end
endmodule

// File: rtl/narrow_conv_chk.sv
module narrow_conv_chk
    import narrow_pkg::*;
#(
    parameter int LANES = 8,
    parameter int MAXVL = 512,
    localparam int SRC_ALL = LANES * SRC_W,
    localparam int LOW_W   = LANES * DST_W
) (
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic [7:0]         opcode,
    input logic [1:0]         vsel,
    input logic [3:0]         reg_spec,
    input logic [SRC_ALL-1:0] src,
    input logic [MAXVL-1:0]   old_dst,
    input logic [LANES-1:0]   mask,
    input logic               mask_en,
    input logic               zero_mask,
    input logic               dst_mem,
    input logic               out_valid,
    input logic [MAXVL-1:0]   out_data,
    input logic [LANES-1:0]   out_wren,
    input logic               out_illegal
);
    logic legal_in;
    assign legal_in = (opcode == 8'h35 || opcode == 8'h25 || opcode == 8'h15)
                      && reg_spec == 4'hF && vsel != 2'd3;

    // R10: one-cycle latency for the valid strobe
    p_valid_rise_r10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_valid_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R9: an illegal result writes no lane
    p_illegal_nowrite_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_illegal |-> out_wren == '0);

    // R2: two-lane length enables only the low two lanes
    p_short_lanes_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid && vsel == 2'd0 |=> out_wren[LANES-1:2] == '0);

    // R6: write enables stay inside the mask
    p_mask_bound_r6: assert property (@(posedge clk) disable iff (rst)
        in_valid && mask_en |=> (out_wren & ~$past(mask)) == '0);

    // R7: legal register result clears the upper half
    p_reg_upper_r7: assert property (@(posedge clk) disable iff (rst)
        in_valid && legal_in && !dst_mem |=> out_data[MAXVL-1:LOW_W] == '0);

    // R4: positive overflow on lane 0 clamps to the signed maximum
    p_ssat_hi_r4: assert property (@(posedge clk) disable iff (rst)
        in_valid && legal_in && opcode == 8'h25 && !mask_en
        && ($signed(src[63:0]) > 64'sh7FFFFFFF)
        |=> out_data[31:0] == 32'h7FFFFFFF);
endmodule

bind narrow_conv_unit narrow_conv_chk #(.LANES(LANES), .MAXVL(MAXVL)) u_chk (.*);

// File: tb/narrow_conv_unit_tb.sv
module narrow_conv_unit_tb;
    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [7:0]   opcode;
    logic [1:0]   vsel;
    logic [3:0]   reg_spec;
    logic [511:0] src;
    logic [511:0] old_dst;
    logic [7:0]   mask;
    logic         mask_en;
    logic         zero_mask;
    logic         dst_mem;
    logic         out_valid;
    logic [511:0] out_data;
    logic [7:0]   out_wren;
    logic         out_illegal;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    narrow_conv_unit u_dut (.*);

    function automatic logic [63:0] val(input int k);
        case (k % 10)
            0: return 64'h0;
            1: return 64'h0000_0000_7FFF_FFFF;
            2: return 64'h0000_0000_8000_0000;
            3: return 64'h0000_0000_FFFF_FFFF;
            4: return 64'h0000_0001_0000_0000;
            5: return 64'hFFFF_FFFF_FFFF_FFFF;
            6: return 64'hFFFF_FFFF_8000_0000;
            7: return 64'hFFFF_FFFF_7FFF_FFFF;
            8: return 64'h8000_0000_0000_0000;
            default: return 64'h1234_5678_9ABC_DEF0;
        endcase
    endfunction

    function automatic logic [31:0] ref_conv(input logic [7:0] op, input logic [63:0] x);
        longint sx;
        sx = longint'(x);
        if (op == 8'h25) begin
            if (sx > 64'sd2147483647) return 32'h7FFF_FFFF;
            if (sx < -64'sd2147483648) return 32'h8000_0000;
            return x[31:0];
        end else if (op == 8'h15) begin
            if (x > 64'hFFFF_FFFF) return 32'hFFFF_FFFF;
            return x[31:0];
        end
        return x[31:0];
    endfunction

    function automatic bit is_legal(input logic [7:0] op, input logic [1:0] vs, input logic [3:0] rs);
        return (op == 8'h35 || op == 8'h25 || op == 8'h15) && rs == 4'hF && vs != 2'd3;
    endfunction

    task automatic check(input string tag, input logic [511:0] act, input logic [511:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic run_case(input string tag, input logic [7:0] op, input logic [1:0] vs,
                            input logic [3:0] rs, input logic me, input logic [7:0] mk,
                            input logic zm, input logic mem, input int pat);
        logic [511:0] e_data;
        logic [7:0]   e_wren;
        int           n;
        bit           lg;
        @(negedge clk);
        opcode = op; vsel = vs; reg_spec = rs; mask_en = me; mask = mk;
        zero_mask = zm; dst_mem = mem;
        for (int j = 0; j < 8; j++) src[j*64 +: 64] = val(j + pat * 3);
        for (int w = 0; w < 16; w++) old_dst[w*32 +: 32] = 32'hC0DE_0000 | 32'(w + pat * 16);
        in_valid = 1'b1;
        lg = is_legal(op, vs, rs);
        n  = 2 << vs;
        e_data = old_dst;
        e_wren = '0;
        if (lg) begin
            for (int w = 0; w < 16; w++) begin
                if (w < n) begin
                    if (!me || mk[w]) begin
                        e_data[w*32 +: 32] = ref_conv(op, src[w*64 +: 64]);
                        e_wren[w] = 1'b1;
                    end else if (zm && !mem) begin
                        e_data[w*32 +: 32] = '0;
                    end
                end else if (!mem) begin
                    e_data[w*32 +: 32] = '0;
                end
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " valid"},   {511'b0, out_valid}, 512'd1);
        check({tag, " data"},    out_data, e_data);
        check({tag, " wren"},    {504'b0, out_wren}, {504'b0, e_wren});
        check({tag, " illegal"}, {511'b0, out_illegal}, {511'b0, !lg});
        @(negedge clk);
        check({tag, " R10 pulse"}, {511'b0, out_valid}, 512'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; opcode = 8'h35; vsel = 2'd0; reg_spec = 4'hF;
        src = '0; old_dst = '0; mask = '0; mask_en = 1'b0; zero_mask = 1'b0; dst_mem = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check("R11 valid", {511'b0, out_valid}, 512'd0);
        check("R11 data", out_data, 512'd0);
        check("R11 wren", {504'b0, out_wren}, 512'd0);
        check("R11 illegal", {511'b0, out_illegal}, 512'd0);

        run_case("R1 trunc",   8'h35, 2'd2, 4'hF, 1'b0, 8'h00, 1'b0, 1'b0, 1);
        run_case("R1 badop",   8'h45, 2'd2, 4'hF, 1'b0, 8'h00, 1'b0, 1'b0, 1);
        run_case("R2 vsel3",   8'h35, 2'd3, 4'hF, 1'b0, 8'h00, 1'b0, 1'b0, 2);
        run_case("R4 ssat",    8'h25, 2'd2, 4'hF, 1'b0, 8'h00, 1'b0, 1'b0, 0);
        run_case("R5 usat",    8'h15, 2'd2, 4'hF, 1'b0, 8'h00, 1'b0, 1'b0, 2);
        run_case("R6 zero",    8'h25, 2'd2, 4'hF, 1'b1, 8'h5A, 1'b1, 1'b0, 1);
        run_case("R6 merge",   8'h25, 2'd2, 4'hF, 1'b1, 8'h5A, 1'b0, 1'b0, 1);
        run_case("R7 upper",   8'h15, 2'd1, 4'hF, 1'b0, 8'h00, 1'b0, 1'b0, 3);
        run_case("R8 memzero", 8'h35, 2'd1, 4'hF, 1'b1, 8'h06, 1'b1, 1'b1, 2);
        run_case("R9 rspec",   8'h25, 2'd2, 4'hE, 1'b0, 8'h00, 1'b0, 1'b0, 0);
        run_case("R9 rspec0",  8'h15, 2'd0, 4'h0, 1'b1, 8'hFF, 1'b1, 1'b1, 1);

        // R3 sweep over every mode, length, destination and masking style
        for (int o = 0; o < 3; o++)
            for (int v = 0; v < 4; v++)
                for (int d = 0; d < 2; d++)
                    for (int z = 0; z < 2; z++)
                        for (int m = 0; m < 2; m++)
                            for (int k = 0; k < 4; k++)
                                for (int p = 0; p < 3; p++)
                                    run_case("R3 sweep",
                                        (o == 0) ? 8'h35 : (o == 1) ? 8'h25 : 8'h15,
                                        2'(v), 4'hF, m[0],
                                        (k == 0) ? 8'hFF : (k == 1) ? 8'h00 :
                                        (k == 2) ? 8'hA5 : 8'h3C,
                                        z[0], d[0], p);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule